// File: doc/BRIEF.md
# Four-Bit Multi-Function Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit for two 4-bit operands. A 4-bit operation code selects one of seven functions: bitwise AND, OR and XOR; addition or subtraction; multiplication; division; and a three-way magnitude comparison. A separate select input chooses between addition and subtraction. The result bus is 8 bits wide, which is enough for the full product and for a quotient and remainder pair. Flags report a carry or active-low borrow, a zero divisor, and the outcome of the comparison.

The multiplier builds its product one column at a time. Each column sums every cross product `a[i] & b[j]` whose index sum equals the column number. It then adds the carry from the column below and passes its own carry upward. The divider is a restoring array divider with one trial-subtract row per quotient bit, so the whole division settles in a single combinational pass. A build parameter can put a synchronous output register after the datapath. Without it the outputs follow the inputs in the same cycle.

Top module: `alu4_top`

## Requirements
- R1: With operation code 4'b0001 and `sub_sel`=0, `res[3:0]` is (A+B) mod 16, `res[7:4]` is 0 and `carry_o` is the carry out of bit 3.
- R2: With operation code 4'b0001 and `sub_sel`=1, `res[3:0]` is (A−B) mod 16, `res[7:4]` is 0 and `carry_o` is 1 exactly when A ≥ B (active-low borrow).
- R3: Operation codes 4'b0010, 4'b0101 and 4'b0111 give bitwise A AND B, A XOR B and A OR B in `res[3:0]`, with `res[7:4]` equal to 0.
- R4: Operation code 4'b0011 gives the unsigned 8-bit product A×B on `res[7:0]`.
- R5: Operation code 4'b0100 with B≠0 gives the quotient A/B in `res[3:0]` and the remainder A mod B in `res[7:4]`, with `dz_o`=0.
- R6: Operation code 4'b0100 with B=0 sets `dz_o`=1, gives 4'hF in `res[3:0]` and A in `res[7:4]`.
- R7: Operation code 4'b0110 gives `res`=0 and raises exactly one of `gt_o` (A>B), `lt_o` (A<B) and `eq_o` (A=B).
- R8: `gt_o`, `lt_o` and `eq_o` are all 0 for every operation code other than 4'b0110.
- R9: Operation code 4'b0000, and every operation code with bit 3 set, gives `res`=0 and all five flags at 0.
- R10: `carry_o` is 0 for every operation code other than 4'b0001, and `dz_o` is 0 for every operation code other than 4'b0100.
- R11: With the output register enabled, the outputs show one clock later what the combinational datapath computed. While `rst` is high at a rising edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_code | input | 4 | Operation code; bit 3 must be 0 for a defined function |
| sub_sel | input | 1 | Chooses subtraction (1) or addition (0) under 4'b0001 |
| opa | input | 4 | Operand A |
| opb | input | 4 | Operand B |
| res | output | 8 | Result bus |
| carry_o | output | 1 | Carry out of the add, or active-low borrow of the subtract |
| dz_o | output | 1 | Divisor was zero |
| gt_o | output | 1 | A greater than B (compare only) |
| lt_o | output | 1 | A less than B (compare only) |
| eq_o | output | 1 | A equal to B (compare only) |

## Verification
Every cycle, the assertions check the following against the operands: the sum and carry of an add, the borrow of a subtract, the product, the quotient and remainder identity for a nonzero divisor, and the zero-divisor pattern. They also check that exactly one compare flag is raised under the compare code, that no compare flag is raised under any other code, that undefined codes produce an all-zero output, and that the registered variant trails the datapath by one cycle. Only the bench's scenarios can show the exact values at the corners, where the operands and codes are chosen on purpose. These include the carry from 15+1, the borrow when B exceeds A, the product 15×15, division of zero and division by zero, and the reset contents of the registered copy. Seeded random vectors across all sixteen codes cover the ordinary cases.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned ALU_W = 4;
    localparam int unsigned RES_W = 2 * ALU_W;
    localparam int unsigned OPC_W = 4;
    localparam int unsigned FN_W  = 3;

    typedef enum logic [FN_W-1:0] {
        FN_NONE   = 3'd0,
        FN_ADDSUB = 3'd1,
        FN_AND    = 3'd2,
        FN_MUL    = 3'd3,
        FN_DIV    = 3'd4,
        FN_XOR    = 3'd5,
        FN_CMP    = 3'd6,
        FN_OR     = 3'd7
    } alu_fn_e;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             carry;
        logic             dz;
        logic             gt;
        logic             lt;
        logic             eq;
    } alu_out_t;

    localparam alu_out_t ALU_OUT_ZERO = '0;

    // Any code with the top bit set maps to the idle function.
    function automatic alu_fn_e decode_fn(input logic [OPC_W-1:0] op);
        if (op[OPC_W-1]) begin
            return FN_NONE;
        end
        return alu_fn_e'(op[FN_W-1:0]);
    endfunction

    function automatic logic [RES_W-1:0] zext(input logic [ALU_W-1:0] v);
        return {{(RES_W - ALU_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] b_eff;
    logic [W:0]   total;

    // Subtraction adds the inverted operand plus one.
    assign b_eff = b ^ {W{sub}};
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign s     = total[W-1:0];
    assign co    = total[W];
endmodule

// File: rtl/alu4_mul_xc.sv
module alu4_mul_xc #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned NCOL = 2 * W - 1;
    localparam int unsigned CW   = $clog2(2 * W) + 2;

    // Column k collects every a[i]&b[j] with i+j=k plus the carry from below.
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        p   = '0;
        for (int k = 0; k < NCOL; k++) begin
            for (int i = 0; i < W; i++) begin
                if ((k - i) >= 0 && (k - i) < W) begin
                    acc = acc + {{(CW-1){1'b0}}, a[i] & b[k - i]};
                end
            end
            p[k] = acc[0];
            acc  = acc >> 1;
        end
        p[2*W-1] = acc[0];
    end
endmodule

// File: rtl/alu4_div_arr.sv
module alu4_div_arr #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q,
    output logic [W-1:0] r,
    output logic         dz
);
    // One trial-subtract row per quotient bit, most significant first.
    // A zero divisor never restores, so q fills with ones and r equals a.
    always_comb begin
        logic [W:0]   rem;
        logic [W+1:0] diff;
        rem = '0;
        q   = '0;
        for (int g = W - 1; g >= 0; g--) begin
            rem  = {rem[W-1:0], a[g]};
            diff = {1'b0, rem} - {2'b00, b};
            if (!diff[W+1]) begin
                rem  = diff[W:0];
                q[g] = 1'b1;
            end
        end
        r  = rem[W-1:0];
        dz = (b == '0);
    end
endmodule

// File: rtl/alu4_top.sv
module alu4_top
    import alu4_pkg::*;
#(
    parameter bit OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] op_code,
    input  logic             sub_sel,
    input  logic [ALU_W-1:0] opa,
    input  logic [ALU_W-1:0] opb,
    output logic [RES_W-1:0] res,
    output logic             carry_o,
    output logic             dz_o,
    output logic             gt_o,
    output logic             lt_o,
    output logic             eq_o
);
    alu_fn_e          fn;
    logic [ALU_W-1:0] as_sum;
    logic             as_co;
    logic [RES_W-1:0] mul_p;
    logic [ALU_W-1:0] div_q;
    logic [ALU_W-1:0] div_r;
    logic             div_z;
    alu_out_t         nx;
    alu_out_t         q_out;

    assign fn = decode_fn(op_code);

    alu4_addsub #(.W(ALU_W)) u_addsub (
        .a(opa), .b(opb), .sub(sub_sel), .s(as_sum), .co(as_co)
    );

    alu4_mul_xc #(.W(ALU_W)) u_mul (
        .a(opa), .b(opb), .p(mul_p)
    );

    alu4_div_arr #(.W(ALU_W)) u_div (
        .a(opa), .b(opb), .q(div_q), .r(div_r), .dz(div_z)
    );

    always_comb begin
        nx = ALU_OUT_ZERO;
        unique case (fn)
            FN_ADDSUB: begin
                nx.res   = zext(as_sum);
                nx.carry = as_co;
            end
            FN_AND: nx.res = zext(opa & opb);
            FN_XOR: nx.res = zext(opa ^ opb);
            FN_OR:  nx.res = zext(opa | opb);
            FN_MUL: nx.res = mul_p;
            FN_DIV: begin
                nx.res = {div_r, div_q};
                nx.dz  = div_z;
            end
            FN_CMP: begin
                nx.gt = (opa > opb);
                nx.lt = (opa < opb);
                nx.eq = (opa == opb);
            end
            default: nx = ALU_OUT_ZERO;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_out <= ALU_OUT_ZERO;
                end else begin
                    q_out <= nx;
                end
            end

            // R11
            reg_lag_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (q_out == $past(nx)));
        end else begin : g_comb
            assign q_out = nx;
        end
    endgenerate

    assign res     = q_out.res;
    assign carry_o = q_out.carry;
    assign dz_o    = q_out.dz;
    assign gt_o    = q_out.gt;
    assign lt_o    = q_out.lt;
    assign eq_o    = q_out.eq;

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_ADDSUB && !sub_sel) |->
            ({nx.carry, nx.res[ALU_W-1:0]} == ({1'b0, opa} + {1'b0, opb})));

    // R2
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_ADDSUB && sub_sel) |-> (nx.carry == (opa >= opb)));

    // R4
    mul_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_MUL) |-> (nx.res == (zext(opa) * zext(opb))));

    // R5
    div_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_DIV && !nx.dz) |->
            ((zext(nx.res[ALU_W-1:0]) * zext(opb) + zext(nx.res[RES_W-1:ALU_W])) == zext(opa)
             && nx.res[RES_W-1:ALU_W] < opb));

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_DIV && opb == '0) |->
            (nx.dz && nx.res == {opa, {ALU_W{1'b1}}}));

    // R7
    cmp_one_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_CMP) |-> ($countones({nx.gt, nx.lt, nx.eq}) == 1 && nx.res == '0));

    // R8
    cmp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fn != FN_CMP) |-> ({nx.gt, nx.lt, nx.eq} == 3'b000));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code[OPC_W-1] || op_code == '0) |-> (nx == ALU_OUT_ZERO));

    // R10
    flag_scope_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((fn == FN_ADDSUB || !nx.carry) && (fn == FN_DIV || !nx.dz)));

endmodule

// File: tb/sim_alu4_top.sv
module sim_alu4_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_code;
    logic       sub_sel;
    logic [3:0] opa;
    logic [3:0] opb;
    logic [7:0] res0, res1;
    logic       c0, z0, g0, l0, e0;
    logic       c1, z1, g1, l1, e1;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #10 clk = ~clk;

    alu4_top #(.OUT_REG(1'b0)) u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .sub_sel(sub_sel),
        .opa(opa), .opb(opb), .res(res0), .carry_o(c0), .dz_o(z0),
        .gt_o(g0), .lt_o(l0), .eq_o(e0)
    );

    alu4_top #(.OUT_REG(1'b1)) u1 (
        .clk(clk), .rst(rst), .op_code(op_code), .sub_sel(sub_sel),
        .opa(opa), .opb(opb), .res(res1), .carry_o(c1), .dz_o(z1),
        .gt_o(g1), .lt_o(l1), .eq_o(e1)
    );

    // Packed as {res[7:0], carry, dz, gt, lt, eq}.
    function automatic logic [12:0] model(input logic [3:0] op, input logic s,
                                          input logic [3:0] a, input logic [3:0] b);
        int         ia = a;
        int         ib = b;
        int         t;
        logic [7:0] r = 8'h00;
        logic       c = 1'b0, dz = 1'b0, gt = 1'b0, lt = 1'b0, eq = 1'b0;
        if (!op[3]) begin
            case (op[2:0])
                3'd1: begin
                    if (!s) begin
                        t = ia + ib;
                        r = 8'(t % 16);
                        c = (t >= 16);
                    end else begin
                        t = ia - ib + 16;
                        r = 8'(t % 16);
                        c = (ia >= ib);
                    end
                end
                3'd2: r = {4'h0, a & b};
                3'd3: r = 8'(ia * ib);
                3'd4: begin
                    if (ib == 0) begin
                        r  = {a, 4'hF};
                        dz = 1'b1;
                    end else begin
                        r = {4'(ia % ib), 4'(ia / ib)};
                    end
                end
                3'd5: r = {4'h0, a ^ b};
                3'd6: begin
                    gt = (ia > ib);
                    lt = (ia < ib);
                    eq = (ia == ib);
                end
                3'd7: r = {4'h0, a | b};
                default: r = 8'h00;
            endcase
        end
        return {r, c, dz, gt, lt, eq};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic s, input logic [3:0] b);
        if (op[3] || op == 4'd0) return "R9";
        case (op[2:0])
            3'd1:    return s ? "R2" : "R1";
            3'd3:    return "R4/R8";
            3'd4:    return (b == 4'd0) ? "R6" : "R5/R10";
            3'd6:    return "R7";
            default: return "R3/R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h sub=%b a=%h b=%h actual=%h expected=%h",
                     tag, op_code, sub_sel, opa, opb, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic s, input logic [3:0] a, input logic [3:0] b);
        logic [12:0] exp;
        @(negedge clk);
        op_code = op; sub_sel = s; opa = a; opb = b;
        exp = model(op, s, a, b);
        #5;
        check(tag_of(op, s, b), {res0, c0, z0, g0, l0, e0}, exp);
        @(posedge clk);
        #5;
        // R11: registered copy shows the value one edge later
        check("R11", {res1, c1, z1, g1, l1, e1}, exp);
    endtask

    initial begin
        rst = 1'b1; op_code = 4'h0; sub_sel = 1'b0; opa = 4'h0; opb = 4'h0;
        repeat (3) @(posedge clk);
        #5;
        // R11: reset contents of the registered copy
        check("R11", {res1, c1, z1, g1, l1, e1}, 13'd0);
        // R9: idle code on the combinational copy
        check("R9", {res0, c0, z0, g0, l0, e0}, 13'd0);
        @(negedge clk);
        op_code = 4'h3; opa = 4'hF; opb = 4'hF;
        @(posedge clk);
        #5;
        // R11: still cleared while reset is held
        check("R11", {res1, c1, z1, g1, l1, e1}, 13'd0);
        @(negedge clk);
        rst = 1'b0;

        apply(4'h1, 1'b0, 4'hF, 4'h1);   // R1 carry out
        apply(4'h1, 1'b0, 4'h7, 4'h8);   // R1 no carry
        apply(4'h1, 1'b1, 4'h3, 4'h5);   // R2 borrow
        apply(4'h1, 1'b1, 4'h5, 4'h5);   // R2 equal, no borrow
        apply(4'h2, 1'b0, 4'hC, 4'hA);   // R3 AND
        apply(4'h5, 1'b1, 4'hC, 4'hA);   // R3 XOR
        apply(4'h7, 1'b0, 4'hC, 4'hA);   // R3 OR
        apply(4'h3, 1'b0, 4'hF, 4'hF);   // R4 225
        apply(4'h3, 1'b0, 4'h0, 4'h9);   // R4 zero
        apply(4'h4, 1'b0, 4'hD, 4'h4);   // R5
        apply(4'h4, 1'b0, 4'h3, 4'hF);   // R5 quotient zero
        apply(4'h4, 1'b0, 4'hB, 4'h0);   // R6
        apply(4'h4, 1'b0, 4'h0, 4'h0);   // R6 zero over zero
        apply(4'h6, 1'b0, 4'h9, 4'h9);   // R7 equal
        apply(4'h6, 1'b0, 4'hA, 4'h2);   // R7 greater
        apply(4'h6, 1'b0, 4'h0, 4'hF);   // R7 less
        apply(4'h0, 1'b1, 4'h9, 4'h9);   // R9 code zero
        apply(4'hE, 1'b0, 4'h9, 4'h9);   // R9, R8 with bit 3 set
        apply(4'h9, 1'b1, 4'hF, 4'hF);   // R9, R10 add code with bit 3 set
        apply(4'hC, 1'b0, 4'h5, 4'h0);   // R9, R10 divide code with bit 3 set

        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            apply(4'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired before the scenarios finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule